// File: doc/BRIEF.md
# Modify Index and Skip Unit

This block carries out the arithmetic and the skip decision of an index-modify instruction, plus a companion index-load mode. On a one-cycle start pulse it picks an operand and a destination from the format flag and the two-bit index tag. The destination is the instruction address register, one of three index registers, or a memory word. It then computes the new value, and a cycle later it presents that value with a write strobe and a skip pulse for the sequencer.

The caller supplies the current register values, the 8-bit displacement field, the second instruction word and the memory data word. The block holds no architectural registers of its own. It only reports what should be written and where, so the surrounding sequencer keeps full control of register and memory updates. The carry and overflow indicators are never touched.

Top module: `msk_unit`

## Requirements
- R1: After reset, `done`, `skip`, `wr_reg` and `mem_we` are all low.
- R2: Modify mode, short format, tag 0: `result` = `iar_in` + sign-extended `disp` (modulo 2^16), `wr_reg`=1 with `wr_sel`=0, and `skip` is never raised, even when the sum is zero.
- R3: Modify mode, short format, tag n (1..3): `result` = index register n + sign-extended `disp`, with `wr_reg`=1 and `wr_sel`=n. Index register n is read from `xr_in[n*16-1 -: 16]`.
- R4: Modify mode, long format, tag n (1..3): `result` = index register n + `mem_rdata`, with `wr_reg`=1 and `wr_sel`=n.
- R5: Modify mode, long format, tag 0: `result` = `mem_rdata` + sign-extended `disp`, `mem_we`=1, `mem_addr`=`word2` and `wr_reg`=0.
- R6: In modify mode, except for the case in R2, `skip` is 1 when the sum is zero or its bit 15 differs from bit 15 of the value being modified, and 0 otherwise.
- R7: Load mode (`load_mode`=1), short format: `result` = sign-extended `disp`, written with `wr_reg`=1 and `wr_sel`=tag (0 means the instruction address register). Nothing is added, and `skip`=0.
- R8: Load mode, long format: `result` = `word2` with `wr_sel`=tag, and `skip`=0 even for a zero value.
- R9: `done` rises exactly one cycle after `start` and lasts one cycle. `skip`, `wr_reg` and `mem_we` are high only while `done` is high.
- R10: All sums wrap modulo 2^16 (for example 7FFF+8001 gives 0000).
- R11: While `start` stays low, `done`, `skip`, `wr_reg` and `mem_we` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to execute |
| load_mode | input | 1 | 0 = modify and skip, 1 = load index |
| long_fmt | input | 1 | 1 = two-word instruction |
| tag | input | 2 | Index select, 0 = none |
| disp | input | 8 | Signed displacement field |
| word2 | input | 16 | Second instruction word |
| mem_rdata | input | 16 | Memory word read for the instruction |
| iar_in | input | 16 | Current instruction address register |
| xr_in | input | 48 | Index registers 1..3, register 1 in the low bits |
| done | output | 1 | Result valid pulse |
| skip | output | 1 | Skip next instruction pulse |
| wr_reg | output | 1 | Write `result` to register `wr_sel` |
| wr_sel | output | 2 | 0 = IAR, 1..3 = index register |
| mem_we | output | 1 | Write `result` to memory at `mem_addr` |
| mem_addr | output | 16 | Memory write address |
| result | output | 16 | New value |

## Verification
The bench aims at sums that land exactly on zero, on the IAR path where a design that applies the skip rule everywhere would wrongly skip. It also covers sums that cross the sign boundary in both directions, which a rule testing only for a negative result would miss on a negative-to-positive change. Long-format cases with and without an index tag check that the memory word is the addend in one case and the destination in the other. A design that mixes these up writes the wrong place or misses `mem_we`. Load-mode vectors with zero values catch a design that adds where it should copy, or that lets the skip rule leak into loads.

// File: rtl/msk_pkg.sv
package msk_pkg;

    typedef enum logic {
        MODE_MODIFY = 1'b0,
        MODE_LOAD   = 1'b1
    } msk_mode_e;

    typedef struct packed {
        logic wr_reg;
        logic mem_we;
        logic skip_en;
        logic replace;
    } msk_ctl_t;

endpackage

// File: rtl/msk_operand_sel.sv
module msk_operand_sel
    import msk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8,
    parameter int NUM_XR = 3,
    localparam int TAG_W = $clog2(NUM_XR + 1)
) (
    input  logic                     load_mode,
    input  logic                     long_fmt,
    input  logic [TAG_W-1:0]         tag,
    input  logic [DISP_W-1:0]        disp,
    input  logic [DATA_W-1:0]        word2,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic [DATA_W-1:0]        iar_in,
    input  logic [NUM_XR*DATA_W-1:0] xr_in,
    output logic [DATA_W-1:0]        base,
    output logic [DATA_W-1:0]        addend,
    output msk_ctl_t                 ctl
);

    localparam int SLOTS = 1 << TAG_W;

    logic [DATA_W-1:0] slot_val [SLOTS];
    logic [DATA_W-1:0] disp_sx;
    logic [DATA_W-1:0] cur_reg;
    msk_mode_e         mode;

    assign slot_val[0] = iar_in;

    genvar gi;
    generate
        for (gi = 1; gi < SLOTS; gi++) begin : g_slot
            if (gi <= NUM_XR) begin : g_xr
                assign slot_val[gi] = xr_in[gi*DATA_W-1 -: DATA_W];
            end else begin : g_pad
                assign slot_val[gi] = '0;
            end
        end
    endgenerate

    assign disp_sx = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign cur_reg = slot_val[tag];
    assign mode    = msk_mode_e'(load_mode);

    always_comb begin
        base   = cur_reg;
        addend = disp_sx;
        ctl    = '0;
        if (mode == MODE_LOAD) begin
            addend      = long_fmt ? word2 : disp_sx;
            ctl.wr_reg  = 1'b1;
            ctl.replace = 1'b1;
        end else if (!long_fmt) begin
            ctl.wr_reg  = 1'b1;
            ctl.skip_en = (tag != '0);
        end else if (tag != '0) begin
            addend      = mem_rdata;
            ctl.wr_reg  = 1'b1;
            ctl.skip_en = 1'b1;
        end else begin
            base        = mem_rdata;
            ctl.mem_we  = 1'b1;
            ctl.skip_en = 1'b1;
        end
    end

endmodule

// File: rtl/msk_sum_skip.sv
module msk_sum_skip #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] addend,
    input  logic              replace,
    input  logic              skip_en,
    output logic [DATA_W-1:0] value,
    output logic              skip_hit
);

    logic [DATA_W-1:0] sum;
    logic              is_zero;
    logic              sign_flip;

    assign sum       = base + addend;
    assign is_zero   = (sum == '0);
    assign sign_flip = sum[DATA_W-1] ^ base[DATA_W-1];
    assign value     = replace ? addend : sum;
    assign skip_hit  = skip_en && !replace && (is_zero || sign_flip);

endmodule

// File: rtl/msk_unit.sv
module msk_unit
    import msk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8,
    parameter int NUM_XR = 3,
    localparam int TAG_W = $clog2(NUM_XR + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     load_mode,
    input  logic                     long_fmt,
    input  logic [TAG_W-1:0]         tag,
    input  logic [DISP_W-1:0]        disp,
    input  logic [DATA_W-1:0]        word2,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic [DATA_W-1:0]        iar_in,
    input  logic [NUM_XR*DATA_W-1:0] xr_in,
    output logic                     done,
    output logic                     skip,
    output logic                     wr_reg,
    output logic [TAG_W-1:0]         wr_sel,
    output logic                     mem_we,
    output logic [DATA_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        result
);

    typedef struct packed {
        logic              done;
        logic              skip;
        logic              wr_reg;
        logic [TAG_W-1:0]  wr_sel;
        logic              mem_we;
        logic [DATA_W-1:0] mem_addr;
        logic [DATA_W-1:0] result;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] base_w, addend_w, value_w;
    msk_ctl_t          ctl_w;
    logic              skip_w;

    msk_operand_sel #(
        .DATA_W (DATA_W),
        .DISP_W (DISP_W),
        .NUM_XR (NUM_XR)
    ) opsel_i (
        .load_mode (load_mode),
        .long_fmt  (long_fmt),
        .tag       (tag),
        .disp      (disp),
        .word2     (word2),
        .mem_rdata (mem_rdata),
        .iar_in    (iar_in),
        .xr_in     (xr_in),
        .base      (base_w),
        .addend    (addend_w),
        .ctl       (ctl_w)
    );

    msk_sum_skip #(
        .DATA_W (DATA_W)
    ) sum_i (
        .base     (base_w),
        .addend   (addend_w),
        .replace  (ctl_w.replace),
        .skip_en  (ctl_w.skip_en),
        .value    (value_w),
        .skip_hit (skip_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = start;
        st_d.skip   = start && skip_w;
        st_d.wr_reg = start && ctl_w.wr_reg;
        st_d.mem_we = start && ctl_w.mem_we;
        if (start) begin
            st_d.wr_sel   = tag;
            st_d.mem_addr = word2;
            st_d.result   = value_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign skip     = st_q.skip;
    assign wr_reg   = st_q.wr_reg;
    assign wr_sel   = st_q.wr_sel;
    assign mem_we   = st_q.mem_we;
    assign mem_addr = st_q.mem_addr;
    assign result   = st_q.result;

endmodule

// File: rtl/msk_unit_chk.sv
module msk_unit_chk #(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8,
    parameter int NUM_XR = 3,
    localparam int TAG_W = $clog2(NUM_XR + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              load_mode,
    input logic              long_fmt,
    input logic [TAG_W-1:0]  tag,
    input logic [DISP_W-1:0] disp,
    input logic [DATA_W-1:0] word2,
    input logic [DATA_W-1:0] iar_in,
    input logic              done,
    input logic              skip,
    input logic              wr_reg,
    input logic              mem_we,
    input logic [DATA_W-1:0] result
);

    a_r9_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r11_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r9_strobes_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (skip || wr_reg || mem_we) |-> done);

    a_r5_one_destination: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_reg && mem_we));

    a_r2_iar_never_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load_mode && !long_fmt && tag == '0) |=> !skip);

    a_r2_iar_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load_mode && !long_fmt && tag == '0) |=>
        result == $past(iar_in) + {{(DATA_W-DISP_W){$past(disp[DISP_W-1])}}, $past(disp)});

    a_r7_load_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load_mode) |=> (!skip && !mem_we));

    a_r8_load_long_value: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load_mode && long_fmt) |=> result == $past(word2));

    a_r5_mem_only_long_untagged: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !(long_fmt && !load_mode && tag == '0)) |=> !mem_we);

endmodule

bind msk_unit msk_unit_chk #(
    .DATA_W (DATA_W),
    .DISP_W (DISP_W),
    .NUM_XR (NUM_XR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_mode (load_mode),
    .long_fmt  (long_fmt),
    .tag       (tag),
    .disp      (disp),
    .word2     (word2),
    .iar_in    (iar_in),
    .done      (done),
    .skip      (skip),
    .wr_reg    (wr_reg),
    .mem_we    (mem_we),
    .result    (result)
);

// File: tb/msk_unit_tb_top.sv
module msk_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        load_mode = 1'b0;
    logic        long_fmt = 1'b0;
    logic [1:0]  tag = '0;
    logic [7:0]  disp = '0;
    logic [15:0] word2 = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] iar_in = '0;
    logic [47:0] xr_in = {16'h7FFF, 16'hFFFE, 16'h0010};
    logic        done, skip, wr_reg, mem_we;
    logic [1:0]  wr_sel;
    logic [15:0] mem_addr, result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    msk_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .load_mode(load_mode),
        .long_fmt(long_fmt), .tag(tag), .disp(disp), .word2(word2),
        .mem_rdata(mem_rdata), .iar_in(iar_in), .xr_in(xr_in),
        .done(done), .skip(skip), .wr_reg(wr_reg), .wr_sel(wr_sel),
        .mem_we(mem_we), .mem_addr(mem_addr), .result(result)
    );

    typedef struct packed {
        logic        ld;
        logic        lng;
        logic [1:0]  tg;
        logic [7:0]  dsp;
        logic [15:0] w2;
        logic [15:0] mem;
        logic [15:0] iar;
        logic [15:0] e_res;
        logic        e_wr;
        logic [1:0]  e_sel;
        logic        e_mem;
        logic        e_skip;
    } vec_t;

    localparam int NV = 17;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0,1'b0,2'd0,8'h05,16'h0000,16'h0000,16'h0100, 16'h0105,1'b1,2'd0,1'b0,1'b0}, // R2
        {1'b0,1'b0,2'd0,8'hFF,16'h0000,16'h0000,16'h0001, 16'h0000,1'b1,2'd0,1'b0,1'b0}, // R2 zero, no skip
        {1'b0,1'b0,2'd1,8'h03,16'h0000,16'h0000,16'h0100, 16'h0013,1'b1,2'd1,1'b0,1'b0}, // R3
        {1'b0,1'b0,2'd1,8'hF0,16'h0000,16'h0000,16'h0100, 16'h0000,1'b1,2'd1,1'b0,1'b1}, // R3 R6 zero
        {1'b0,1'b0,2'd2,8'h01,16'h0000,16'h0000,16'h0100, 16'hFFFF,1'b1,2'd2,1'b0,1'b0}, // R6 stays negative
        {1'b0,1'b0,2'd2,8'h02,16'h0000,16'h0000,16'h0100, 16'h0000,1'b1,2'd2,1'b0,1'b1}, // R6 zero
        {1'b0,1'b0,2'd3,8'h01,16'h0000,16'h0000,16'h0100, 16'h8000,1'b1,2'd3,1'b0,1'b1}, // R10 R6 flip
        {1'b0,1'b1,2'd1,8'h00,16'h1234,16'h0005,16'h0100, 16'h0015,1'b1,2'd1,1'b0,1'b0}, // R4
        {1'b0,1'b1,2'd2,8'h00,16'h1234,16'h0003,16'h0100, 16'h0001,1'b1,2'd2,1'b0,1'b1}, // R4 R6 neg->pos
        {1'b0,1'b1,2'd3,8'h00,16'h1234,16'h8001,16'h0100, 16'h0000,1'b1,2'd3,1'b0,1'b1}, // R10 wrap
        {1'b0,1'b1,2'd0,8'h02,16'h0200,16'hFFFD,16'h0100, 16'hFFFF,1'b0,2'd0,1'b1,1'b0}, // R5
        {1'b0,1'b1,2'd0,8'hFF,16'h0300,16'h0001,16'h0100, 16'h0000,1'b0,2'd0,1'b1,1'b1}, // R5 R6 zero
        {1'b0,1'b1,2'd0,8'h01,16'h0400,16'h7FFF,16'h0100, 16'h8000,1'b0,2'd0,1'b1,1'b1}, // R5 R6 flip
        {1'b1,1'b0,2'd0,8'h80,16'h0000,16'h0000,16'h0100, 16'hFF80,1'b1,2'd0,1'b0,1'b0}, // R7 IAR
        {1'b1,1'b0,2'd2,8'h7F,16'h0000,16'h0000,16'h0100, 16'h007F,1'b1,2'd2,1'b0,1'b0}, // R7 XR
        {1'b1,1'b1,2'd0,8'h00,16'hABCD,16'h1111,16'h0100, 16'hABCD,1'b1,2'd0,1'b0,1'b0}, // R8
        {1'b1,1'b1,2'd3,8'h00,16'h0000,16'h2222,16'h0100, 16'h0000,1'b1,2'd3,1'b0,1'b0}  // R8 zero
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", 16'(done), 16'h0);
        chk("R1", "skip", 16'(skip), 16'h0);
        chk("R1", "wr_reg", 16'(wr_reg), 16'h0);
        chk("R1", "mem_we", 16'(mem_we), 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            @(negedge clk);
            load_mode = v.ld; long_fmt = v.lng; tag = v.tg; disp = v.dsp;
            word2 = v.w2; mem_rdata = v.mem; iar_in = v.iar; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9", $sformatf("v%0d done", i), 16'(done), 16'h1);
            chk("R2 R3 R4 R5 R7 R8", $sformatf("v%0d result", i), result, v.e_res);
            chk("R3 R4 R7", $sformatf("v%0d wr_reg", i), 16'(wr_reg), 16'(v.e_wr));
            if (v.e_wr) chk("R3 R7 R8", $sformatf("v%0d wr_sel", i), 16'(wr_sel), 16'(v.e_sel));
            chk("R5", $sformatf("v%0d mem_we", i), 16'(mem_we), 16'(v.e_mem));
            if (v.e_mem) chk("R5", $sformatf("v%0d mem_addr", i), mem_addr, v.w2);
            chk("R6", $sformatf("v%0d skip", i), 16'(skip), 16'(v.e_skip));
            @(negedge clk);
            chk("R9", $sformatf("v%0d done drops", i), 16'(done), 16'h0);
            chk("R9", $sformatf("v%0d skip drops", i), 16'(skip), 16'h0);
        end

        // R11: inputs that would skip and write memory, but no start
        load_mode = 1'b0; long_fmt = 1'b1; tag = 2'd0; disp = 8'hFF; mem_rdata = 16'h0001;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R11", "idle done", 16'(done), 16'h0);
            chk("R11", "idle mem_we", 16'(mem_we), 16'h0);
            chk("R11", "idle skip", 16'(skip), 16'h0);
        end

        // R9: back-to-back starts give a done each cycle, then stop
        @(negedge clk);
        long_fmt = 1'b0; tag = 2'd1; disp = 8'h01; start = 1'b1;
        @(negedge clk);
        chk("R9", "b2b first done", 16'(done), 16'h1);
        chk("R3", "b2b first result", result, 16'h0011);
        disp = 8'h02;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "b2b second done", 16'(done), 16'h1);
        chk("R3", "b2b second result", result, 16'h0012);
        @(negedge clk);
        chk("R9", "b2b end", 16'(done), 16'h0);

        // R1: reset mid-stream clears strobes
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", "async reset done", 16'(done), 16'h0);
        chk("R1", "async reset wr_reg", 16'(wr_reg), 16'h0);

        finish_run();
    end

endmodule